// File: doc/BRIEF.md
# Transceiver State Permission Controller

This block holds the operating state of a CAN FD transceiver inside a system-basis chip, together with the chip operating mode it was accepted under. Software asks for a transceiver state (off, on, listen or wake-capable) through a 3-bit code. The chip's mode sequencer asks for a new chip mode (normal, standby, sleep, restart or fail-safe). Each chip mode permits only some transceiver states. A request that would break that pairing is refused, the stored values stay as they were, and a sticky mode-error flag is raised for software to read and clear.

A configuration bit ties the transceiver to the chip mode. While it is set, the transceiver state follows the accepted chip mode on its own, and state writes from software are dropped. A second bit chooses whether the transceiver is switched off instead of left wake-capable when the chip enters fail-safe. All decisions take effect at the clock edge that samples the request, so the outputs show the result one cycle later.

Top module: `xcvr_state_ctrl`

## Requirements
- R1: Transceiver codes are off = 3'd0, on = 3'd1, listen = 3'd2, wake-capable = 3'd3. Chip mode codes are normal = 3'd0, standby = 3'd1, sleep = 3'd2, restart = 3'd3, fail-safe = 3'd4. After reset the chip mode is standby, the state is wake-capable and the error flag is clear.
- R2: While the tie bit is 1, the state becomes on when the accepted chip mode is normal and wake-capable in standby, sleep and restart.
- R3: While untied, a chip mode request other than fail-safe whose target does not permit the current state is refused: the chip mode and the state do not change and the error flag sets.
- R4: A state write that the current chip mode does not permit is ignored and sets the error flag.
- R5: Normal mode permits all four transceiver states.
- R6: Standby permits off, listen and wake-capable and refuses on.
- R7: Sleep, restart and fail-safe permit only off and wake-capable.
- R8: A fail-safe request is always accepted and sets the state to wake-capable, or to off when the fail-safe-off bit is 1; this holds tied or untied.
- R9: The error flag holds until a clear pulse; a clear in the same cycle as a new refusal leaves it set.
- R10: State codes 3'd4 to 3'd7 and chip mode codes 3'd5 to 3'd7 are refused and set the error flag.
- R11: When a chip mode request and a state write arrive in the same cycle, the chip mode request is handled and the state write is dropped without an error.
- R12: While tied, state writes are dropped without an error and do not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_req_vld_i | input | 1 | Chip mode request strobe |
| mode_req_i | input | MODE_W | Requested chip mode code |
| state_wr_i | input | 1 | Transceiver state write strobe |
| state_req_i | input | STATE_W | Requested transceiver state code |
| tie_mode_i | input | 1 | 1: state follows chip mode |
| fs_off_i | input | 1 | 1: fail-safe entry switches transceiver off |
| err_clr_i | input | 1 | Clears the mode-error flag |
| chip_mode_o | output | MODE_W | Accepted chip mode |
| xcvr_state_o | output | STATE_W | Active transceiver state |
| mode_err_o | output | 1 | Sticky mode-error flag |

## Verification
The bench builds the block with its default widths of three bits for both codes, which leaves the unused state codes 4 to 7 and mode codes 5 to 7 on the request buses, so refusal of undefined codes can be driven directly. With these widths every pairing of chip mode and state in the permission map can be reached through the normal request path, including fail-safe entry from a state that fail-safe would otherwise refuse, and the clash between a clear pulse and a fresh refusal.

// File: rtl/xsp_pkg.sv
package xsp_pkg;

   localparam int CODE_W = 3;
   localparam int NUM_XS = 4;

   typedef enum logic [CODE_W-1:0] {
      XS_OFF    = 3'd0,
      XS_ON     = 3'd1,
      XS_LISTEN = 3'd2,
      XS_WAKE   = 3'd3
   } xs_e;

   typedef enum logic [CODE_W-1:0] {
      CM_NORMAL   = 3'd0,
      CM_STANDBY  = 3'd1,
      CM_SLEEP    = 3'd2,
      CM_RESTART  = 3'd3,
      CM_FAILSAFE = 3'd4
   } cm_e;

   localparam int NUM_CM = 5;

   // Permission mask per chip mode, bit index = transceiver code.
   function automatic logic [NUM_XS-1:0] permit_mask(input int mode);
      case (mode)
         0:       return 4'b1111;
         1:       return 4'b1101;
         2, 3, 4: return 4'b1001;
         default: return 4'b0000;
      endcase
   endfunction

endpackage

// File: rtl/xsp_permit.sv
module xsp_permit #(
   parameter int STATE_W = 3,
   parameter int MODE_W  = 3
) (
   input  logic [MODE_W-1:0]  mode_i,
   input  logic [STATE_W-1:0] state_i,
   output logic               ok_o
);
   import xsp_pkg::*;

   localparam int NMODE = 1 << MODE_W;

   logic [NUM_XS-1:0] mask [NMODE];

   for (genvar m = 0; m < NMODE; m++) begin : g_mask
      assign mask[m] = permit_mask(m);
   end

   logic state_known;
   assign state_known = (state_i < STATE_W'(NUM_XS));

   always_comb begin
      ok_o = 1'b0;
      if (state_known) ok_o = mask[mode_i][state_i[1:0]];
   end

endmodule

// File: rtl/xsp_err_flag.sv
module xsp_err_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_o <= 1'b0;
      else if (set_i)  flag_o <= 1'b1;
      else if (clr_i)  flag_o <= 1'b0;
   end

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o);

   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);

   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/xcvr_state_ctrl.sv
module xcvr_state_ctrl #(
   parameter int STATE_W = 3,
   parameter int MODE_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_req_vld_i,
   input  logic [MODE_W-1:0]  mode_req_i,
   input  logic               state_wr_i,
   input  logic [STATE_W-1:0] state_req_i,
   input  logic               tie_mode_i,
   input  logic               fs_off_i,
   input  logic               err_clr_i,
   output logic [MODE_W-1:0]  chip_mode_o,
   output logic [STATE_W-1:0] xcvr_state_o,
   output logic               mode_err_o
);
   import xsp_pkg::*;

   localparam logic [STATE_W-1:0] ST_OFF  = STATE_W'(XS_OFF);
   localparam logic [STATE_W-1:0] ST_ON   = STATE_W'(XS_ON);
   localparam logic [STATE_W-1:0] ST_WAKE = STATE_W'(XS_WAKE);
   localparam logic [MODE_W-1:0]  MD_NORM = MODE_W'(CM_NORMAL);
   localparam logic [MODE_W-1:0]  MD_STBY = MODE_W'(CM_STANDBY);
   localparam logic [MODE_W-1:0]  MD_FS   = MODE_W'(CM_FAILSAFE);

   if (STATE_W < CODE_W) begin : g_chk_state
      $error("STATE_W must hold every transceiver code");
   end
   if (MODE_W < CODE_W) begin : g_chk_mode
      $error("MODE_W must hold every chip mode code");
   end

   logic [MODE_W-1:0]  mode_q, mode_d;
   logic [STATE_W-1:0] state_q, state_d;
   logic               entry_ok, req_ok, mode_known, err_set;

   // Target mode against the present state; present mode against the write.
   xsp_permit #(.STATE_W(STATE_W), .MODE_W(MODE_W)) u_entry (
      .mode_i (mode_req_i),
      .state_i(state_q),
      .ok_o   (entry_ok)
   );

   xsp_permit #(.STATE_W(STATE_W), .MODE_W(MODE_W)) u_write (
      .mode_i (mode_q),
      .state_i(state_req_i),
      .ok_o   (req_ok)
   );

   assign mode_known = (mode_req_i < MODE_W'(NUM_CM));

   always_comb begin
      mode_d  = mode_q;
      state_d = state_q;
      err_set = 1'b0;
      if (mode_req_vld_i) begin
         if (!mode_known) begin
            err_set = 1'b1;
         end else if (tie_mode_i || mode_req_i == MD_FS || entry_ok) begin
            mode_d = mode_req_i;
            if (mode_req_i == MD_FS) state_d = fs_off_i ? ST_OFF : ST_WAKE;
         end else begin
            err_set = 1'b1;
         end
      end else if (state_wr_i && !tie_mode_i) begin
         if (req_ok) state_d = state_req_i;
         else        err_set = 1'b1;
      end
      if (tie_mode_i) begin
         if (mode_d == MD_NORM)    state_d = ST_ON;
         else if (mode_d == MD_FS) state_d = fs_off_i ? ST_OFF : ST_WAKE;
         else                      state_d = ST_WAKE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MD_STBY;
         state_q <= ST_WAKE;
      end else begin
         mode_q  <= mode_d;
         state_q <= state_d;
      end
   end

   xsp_err_flag u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (err_set),
      .clr_i (err_clr_i),
      .flag_o(mode_err_o)
   );

   assign chip_mode_o  = mode_q;
   assign xcvr_state_o = state_q;

   p_code_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (xcvr_state_o < STATE_W'(NUM_XS)) && (chip_mode_o < MODE_W'(NUM_CM)));

   p_tied_normal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tie_mode_i && mode_req_vld_i && mode_req_i == MD_NORM) |=> xcvr_state_o == ST_ON);

   p_mode_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_req_vld_i && !tie_mode_i && mode_known && mode_req_i != MD_FS && !entry_ok)
      |=> ($stable(chip_mode_o) && $stable(xcvr_state_o) && mode_err_o));

   p_write_refused_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_wr_i && !mode_req_vld_i && !tie_mode_i && !req_ok)
      |=> ($stable(xcvr_state_o) && mode_err_o));

   p_standby_no_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_mode_o == MD_STBY && !tie_mode_i) |-> xcvr_state_o != ST_ON);

   p_low_modes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_mode_o != MD_NORM && chip_mode_o != MD_STBY)
      |-> (xcvr_state_o == ST_OFF || xcvr_state_o == ST_WAKE));

   p_failsafe_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_req_vld_i && mode_req_i == MD_FS)
      |=> (chip_mode_o == MD_FS && xcvr_state_o == ($past(fs_off_i) ? ST_OFF : ST_WAKE)));

endmodule

// File: tb/xcvr_state_ctrl_bench.sv
module xcvr_state_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_req_vld_i = 1'b0;
   logic [2:0] mode_req_i = 3'd0;
   logic       state_wr_i = 1'b0;
   logic [2:0] state_req_i = 3'd0;
   logic       tie_mode_i = 1'b0;
   logic       fs_off_i = 1'b0;
   logic       err_clr_i = 1'b0;
   logic [2:0] chip_mode_o;
   logic [2:0] xcvr_state_o;
   logic       mode_err_o;

   int n_vec = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   xcvr_state_ctrl u_xcvr_state_ctrl (
      .clk(clk), .rst_n(rst_n),
      .mode_req_vld_i(mode_req_vld_i), .mode_req_i(mode_req_i),
      .state_wr_i(state_wr_i), .state_req_i(state_req_i),
      .tie_mode_i(tie_mode_i), .fs_off_i(fs_off_i), .err_clr_i(err_clr_i),
      .chip_mode_o(chip_mode_o), .xcvr_state_o(xcvr_state_o), .mode_err_o(mode_err_o)
   );

   typedef struct packed {
      logic [3:0] rq;
      logic       mv;
      logic [2:0] md;
      logic       sv;
      logic [2:0] st;
      logic       tie;
      logic       fso;
      logic       clr;
      logic [2:0] em;
      logic [2:0] es;
      logic       ee;
   } vec_t;

   // modes N=0 SB=1 SL=2 RS=3 FS=4; states OFF=0 ON=1 LS=2 WC=3
   localparam int NV = 26;
   localparam vec_t VEC [NV] = '{
      '{4'd4,  1'b0, 3'd0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 3'd1, 3'd3, 1'b1}, // R4 on refused in standby
      '{4'd9,  1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 3'd1, 3'd3, 1'b0}, // R9 clear
      '{4'd6,  1'b0, 3'd0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 3'd1, 3'd2, 1'b0}, // R6 listen in standby
      '{4'd3,  1'b1, 3'd2, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd1, 3'd2, 1'b1}, // R3 sleep refused
      '{4'd9,  1'b0, 3'd0, 1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 3'd1, 3'd3, 1'b0}, // R9 clear + write
      '{4'd7,  1'b1, 3'd2, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd2, 3'd3, 1'b0}, // R7 enter sleep
      '{4'd7,  1'b0, 3'd0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 3'd2, 3'd3, 1'b1}, // R7 listen refused
      '{4'd7,  1'b0, 3'd0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 3'd2, 3'd0, 1'b0}, // R7 off in sleep
      '{4'd5,  1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0}, // R5 normal with off
      '{4'd5,  1'b0, 3'd0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 3'd0, 3'd2, 1'b0}, // R5 listen
      '{4'd5,  1'b0, 3'd0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 3'd0, 3'd1, 1'b0}, // R5 on
      '{4'd3,  1'b1, 3'd1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd1, 1'b1}, // R3 standby refused
      '{4'd10, 1'b0, 3'd0, 1'b1, 3'd5, 1'b0, 1'b0, 1'b1, 3'd0, 3'd1, 1'b1}, // R10 / R9 set wins
      '{4'd9,  1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 3'd0, 3'd1, 1'b0}, // R9 clear
      '{4'd8,  1'b1, 3'd4, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd4, 3'd3, 1'b0}, // R8 fail-safe wake
      '{4'd7,  1'b0, 3'd0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 3'd4, 3'd3, 1'b1}, // R7 listen refused
      '{4'd7,  1'b1, 3'd3, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 3'd3, 3'd3, 1'b0}, // R7 restart ok
      '{4'd2,  1'b1, 3'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 3'd0, 3'd1, 1'b0}, // R2 tied normal
      '{4'd12, 1'b0, 3'd0, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 3'd0, 3'd1, 1'b0}, // R12 tied write dropped
      '{4'd2,  1'b1, 3'd2, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 3'd2, 3'd3, 1'b0}, // R2 tied sleep
      '{4'd5,  1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd3, 1'b0}, // R5 untied normal
      '{4'd8,  1'b1, 3'd4, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 3'd4, 3'd0, 1'b0}, // R8 fail-safe off
      '{4'd10, 1'b1, 3'd6, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd4, 3'd0, 1'b1}, // R10 bad mode
      '{4'd11, 1'b1, 3'd0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1}, // R11 mode wins
      '{4'd9,  1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 3'd0, 3'd0, 1'b0}, // R9 clear
      '{4'd8,  1'b1, 3'd4, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 3'd4, 3'd0, 1'b0}  // R8 tied fail-safe off
   };

   task automatic check(input string tag, input logic [2:0] em, input logic [2:0] es,
                        input logic ee);
      n_vec++;
      if (chip_mode_o !== em || xcvr_state_o !== es || mode_err_o !== ee) begin
         n_bad++;
         $display("FAIL %s: mode/state/err got %0d/%0d/%0d expected %0d/%0d/%0d",
                  tag, chip_mode_o, xcvr_state_o, mode_err_o, em, es, ee);
      end
   endtask

   task automatic idle();
      mode_req_vld_i = 1'b0;
      state_wr_i     = 1'b0;
      err_clr_i      = 1'b0;
   endtask

   initial begin
      #2000000;
      n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", 3'd1, 3'd3, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 3'd1, 3'd3, 1'b0);

      for (int i = 0; i < NV; i++) begin
         mode_req_vld_i = VEC[i].mv;
         mode_req_i     = VEC[i].md;
         state_wr_i     = VEC[i].sv;
         state_req_i    = VEC[i].st;
         tie_mode_i     = VEC[i].tie;
         fs_off_i       = VEC[i].fso;
         err_clr_i      = VEC[i].clr;
         @(posedge clk);
         @(negedge clk);
         check($sformatf("R%0d vector %0d", VEC[i].rq, i), VEC[i].em, VEC[i].es, VEC[i].ee);
      end

      // idle cycles hold everything
      idle();
      tie_mode_i = 1'b0;
      fs_off_i   = 1'b0;
      repeat (3) @(negedge clk);
      check("R9 idle hold", 3'd4, 3'd0, 1'b0);

      // R10: undefined state code in normal mode
      mode_req_vld_i = 1'b1; mode_req_i = 3'd0;
      @(negedge clk);
      idle();
      state_wr_i = 1'b1; state_req_i = 3'd7;
      @(negedge clk);
      idle();
      check("R10 state code 7", 3'd0, 3'd0, 1'b1);

      // R2: tie bit alone makes state follow standby
      err_clr_i = 1'b1;
      mode_req_vld_i = 1'b1; mode_req_i = 3'd1; tie_mode_i = 1'b1;
      @(negedge clk);
      idle();
      check("R2 tied standby", 3'd1, 3'd3, 1'b0);

      // R1: reset mid-run
      tie_mode_i = 1'b0;
      mode_req_vld_i = 1'b1; mode_req_i = 3'd0;
      @(negedge clk);
      idle();
      state_wr_i = 1'b1; state_req_i = 3'd9 - 3'd8;
      @(negedge clk);
      idle();
      check("R5 on before reset", 3'd0, 3'd1, 1'b0);
      rst_n = 1'b0;
      #3;
      check("R1 async reset", 3'd1, 3'd3, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 post reset", 3'd1, 3'd3, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule